// File: doc/BRIEF.md
# Multi-Domain Clock Source Controller

This block drives three gated clocks (system, receive, transmit). Each one comes from either a 19.2 MHz crystal reference or a 125 MHz PLL output, or is held off. A 6-bit control field holds one 2-bit mode for each domain. The field lives in a small control word that is written from the reference-clock side.

In automatic mode, the system clock starts on the reference. It moves to the PLL once the PLL reports lock, and moves back to the reference if lock is lost. The receive and transmit clocks work differently in automatic mode: each stays off until the transceiver sequencer raises that domain's activity flag, and then runs from the PLL. Forced modes pin a domain to one source or hold it off.

Every change of source goes through a glitch-free handover:
- The outgoing clock is disabled on one of its own falling edges.
- The incoming clock is enabled on one of its own falling edges, after the outgoing side has released.
- Each side uses a two-stage synchronizer.

A 2-bit status per domain reports which source is actually gating that domain's output.

Top module: `clk_src_ctrl`

## Requirements
- R1: While rst_ni is low, all three outputs are low and all three status outputs read 00. The control word reads back 0, so every domain is in automatic mode (code 00) after reset.
- R2: System field, control bits 1:0, code 00 (automatic):
  - With pll_lock_i high, the system clock runs from the PLL and sys_src_o reads 10.
  - With pll_lock_i low, it runs from the reference and sys_src_o reads 01.
  - When lock drops, the system clock returns to the reference.
- R3: System code 01 forces the reference and system code 10 forces the PLL, in both cases whatever the state of pll_lock_i.
- R4: System code 11 behaves exactly as code 00.
- R5: If the system clock is forced to the PLL while the PLL clock is not toggling, the system output stays low and sys_src_o reads 00. The system clock starts running from the PLL once the PLL clock toggles.
- R6: Receive field, control bits 3:2, code 00 (automatic): the receive clock is off (status 00) while rx_act_i is low, and runs from the PLL (status 10) while it is high.
- R7: Receive code 01 forces the reference (status 01), code 10 forces the PLL (status 10), and code 11 forces the clock off (status 00) even while rx_act_i is high.
- R8: Transmit field, control bits 5:4, uses the same four codes as R6 and R7, with tx_act_i as its demand flag.
- R9: Bits 5:0 of the control word read back the last value written. The reserved bits 7:6 always read their reset value (0), and writes to them are ignored.
- R10: Status encoding is 00 off, 01 reference, 10 PLL.
  - A status never reads 11; the two sources never gate a domain together.
  - A status changes to the new source only once that source is enabled.
  - No pulse on a domain output is shorter than half a period of the faster source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | 19.2 MHz crystal reference clock; also clocks the control word |
| pll_clk_i | input | 1 | 125 MHz PLL clock |
| pll_lock_i | input | 1 | PLL locked flag |
| rx_act_i | input | 1 | Receive operation needs its clock |
| tx_act_i | input | 1 | Transmit operation needs its clock |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | CFG_W | Control word write data |
| cfg_rdata_o | output | CFG_W | Control word read-back |
| sys_clk_o | output | 1 | Gated system clock |
| rx_clk_o | output | 1 | Gated receive clock |
| tx_clk_o | output | 1 | Gated transmit clock |
| sys_src_o | output | 2 | System clock source status |
| rx_src_o | output | 2 | Receive clock source status |
| tx_src_o | output | 2 | Transmit clock source status |

## Verification
The bench walks the mode codes of all three fields and pairs each one with both lock levels and both demand levels. This separates automatic handover from forced selection, and separates the reserved system code from the receive and transmit forced-off code.

For each setting, the bench counts output edges over a fixed window and checks the count against the reported status. This tells a reference-driven domain, a PLL-driven domain and a stalled domain apart, independent of the status bits themselves.

The PLL clock is then stopped with the system clock forced to the PLL, which exposes the stall. Minimum pulse widths are tracked across every switch to catch runt pulses.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned DOM_N = 3;
  localparam int unsigned DOM_SYS = 0;
  localparam int unsigned DOM_RX  = 1;
  localparam int unsigned DOM_TX  = 2;

  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_REF   = 2'b01,
    MODE_PLL   = 2'b10,
    MODE_ALT   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_REF = 2'b01,
    SRC_PLL = 2'b10
  } src_e;
endpackage

// File: rtl/clk_src_cfg.sv
module clk_src_cfg #(
  parameter int unsigned CFG_W = 8,
  parameter int unsigned FLD_W = 6,
  parameter logic [CFG_W-1:0] RSVD_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [FLD_W-1:0] fld_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic [FLD_W-1:0] fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fld_q <= '0;
    else if (we_i) fld_q <= wdata_i[FLD_W-1:0];
  end

  assign fld_o = fld_q;

  generate
    if (CFG_W > FLD_W) begin : g_rsvd
      // reserved bits are constant: read back reset value, writes dropped
      assign rdata_o = {RSVD_RST[CFG_W-1:FLD_W], fld_q};
    end else begin : g_full
      assign rdata_o = fld_q;
    end
  endgenerate
endmodule

// File: rtl/clk_src_policy.sv
module clk_src_policy
  import clk_src_pkg::*;
#(
  parameter bit IS_SYS = 1'b0
) (
  input  logic [SEL_W-1:0] mode_i,
  input  logic             lock_i,
  input  logic             demand_i,
  output logic             want_ref_o,
  output logic             want_pll_o
);
  logic auto_go;

  // system domain follows PLL lock, rx/tx follow their demand flag
  assign auto_go = IS_SYS ? lock_i : demand_i;

  always_comb begin
    want_ref_o = 1'b0;
    want_pll_o = 1'b0;
    unique case (mode_e'(mode_i))
      MODE_AUTO: begin
        want_pll_o = auto_go;
        want_ref_o = IS_SYS && !auto_go;
      end
      MODE_REF: want_ref_o = 1'b1;
      MODE_PLL: want_pll_o = 1'b1;
      MODE_ALT: begin
        // system: reserved code acts as auto; rx/tx: forced off
        if (IS_SYS) begin
          want_pll_o = auto_go;
          want_ref_o = !auto_go;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/clk_gf_mux.sv
module clk_gf_mux (
  input  logic       ref_clk_i,
  input  logic       pll_clk_i,
  input  logic       rst_ni,
  input  logic       want_ref_i,
  input  logic       want_pll_i,
  output logic       clk_o,
  output logic [1:0] src_o
);
  logic ref_s1_q, ref_en_q;
  logic pll_s1_q, pll_en_q;

  // each side arms only after the other side has released
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_s1_q <= 1'b0;
    else         ref_s1_q <= want_ref_i && !pll_en_q;
  end

  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_en_q <= 1'b0;
    else         ref_en_q <= ref_s1_q;
  end

  always_ff @(posedge pll_clk_i or negedge rst_ni) begin
    if (!rst_ni) pll_s1_q <= 1'b0;
    else         pll_s1_q <= want_pll_i && !ref_en_q;
  end

  always_ff @(negedge pll_clk_i or negedge rst_ni) begin
    if (!rst_ni) pll_en_q <= 1'b0;
    else         pll_en_q <= pll_s1_q;
  end

  // enables change only while their own clock is low
  assign clk_o = (ref_clk_i & ref_en_q) | (pll_clk_i & pll_en_q);
  assign src_o = {pll_en_q, ref_en_q};
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int unsigned CFG_W = 8,
  parameter logic [CFG_W-1:0] RSVD_RST = '0
) (
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             pll_clk_i,
  input  logic             pll_lock_i,
  input  logic             rx_act_i,
  input  logic             tx_act_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             sys_clk_o,
  output logic             rx_clk_o,
  output logic             tx_clk_o,
  output logic [1:0]       sys_src_o,
  output logic [1:0]       rx_src_o,
  output logic [1:0]       tx_src_o
);
  localparam int unsigned FLD_W = DOM_N * SEL_W;

  logic [FLD_W-1:0] fld;
  logic [DOM_N-1:0] demand;
  logic [DOM_N-1:0] want_ref, want_pll, dom_clk;
  logic [1:0]       dom_src [DOM_N];

  clk_src_cfg #(
    .CFG_W   (CFG_W),
    .FLD_W   (FLD_W),
    .RSVD_RST(RSVD_RST)
  ) u_cfg (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .fld_o  (fld),
    .rdata_o(cfg_rdata_o)
  );

  assign demand = {tx_act_i, rx_act_i, 1'b0};

  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    clk_src_policy #(
      .IS_SYS(d == DOM_SYS)
    ) u_pol (
      .mode_i    (fld[d*SEL_W +: SEL_W]),
      .lock_i    (pll_lock_i),
      .demand_i  (demand[d]),
      .want_ref_o(want_ref[d]),
      .want_pll_o(want_pll[d])
    );

    clk_gf_mux u_mux (
      .ref_clk_i (ref_clk_i),
      .pll_clk_i (pll_clk_i),
      .rst_ni    (rst_ni),
      .want_ref_i(want_ref[d]),
      .want_pll_i(want_pll[d]),
      .clk_o     (dom_clk[d]),
      .src_o     (dom_src[d])
    );
  end

  assign sys_clk_o = dom_clk[DOM_SYS];
  assign rx_clk_o  = dom_clk[DOM_RX];
  assign tx_clk_o  = dom_clk[DOM_TX];
  assign sys_src_o = dom_src[DOM_SYS];
  assign rx_src_o  = dom_src[DOM_RX];
  assign tx_src_o  = dom_src[DOM_TX];
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk #(
  parameter int unsigned CFG_W = 8,
  parameter logic [CFG_W-1:0] RSVD_RST = '0
) (
  input logic             rst_ni,
  input logic             ref_clk_i,
  input logic             pll_lock_i,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic [1:0]       sys_src_o,
  input logic [1:0]       rx_src_o,
  input logic [1:0]       tx_src_o
);
  // R10
  src_excl_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (sys_src_o != 2'b11) && (rx_src_o != 2'b11) && (tx_src_o != 2'b11));

  // R9
  rsvd_const_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cfg_rdata_o[CFG_W-1:6] == RSVD_RST[CFG_W-1:6]);

  // R9
  wr_readback_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o[5:0] == $past(cfg_wdata_i[5:0]));

  // R7
  rx_off_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[3:2] == 2'b11 && $past(cfg_rdata_o[3:2]) == 2'b11 &&
     $past(cfg_rdata_o[3:2], 2) == 2'b11) |-> rx_src_o == 2'b00);

  // R2
  sys_nolock_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[1:0] == 2'b00 && !pll_lock_i && !$past(pll_lock_i) &&
     !$past(pll_lock_i, 2) && $past(cfg_rdata_o[1:0], 2) == 2'b00)
    |-> sys_src_o != 2'b10);
endmodule

bind clk_src_ctrl clk_src_ctrl_chk #(.CFG_W(CFG_W), .RSVD_RST(RSVD_RST)) u_chk (.*);

// File: tb/sim_clk_src_ctrl.sv
`timescale 1ns/1ps
module sim_clk_src_ctrl;
  logic clk = 1'b0;
  logic ref_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic pll_on = 1'b1;
  logic rst_n = 1'b0;
  logic lock = 1'b0, rx_act = 1'b0, tx_act = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic sys_clk, rx_clk, tx_clk;
  logic [1:0] sys_src, rx_src, tx_src;

  int checks = 0, errors = 0;
  int n_sys = 0, n_rx = 0, n_tx = 0;
  real t_rise = -1.0, t_fall = -1.0, min_w = 1000.0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #26 ref_clk = ~ref_clk;
  always #4 pll_clk = pll_on ? ~pll_clk : 1'b0;

  clk_src_ctrl u0 (
    .rst_ni(rst_n), .ref_clk_i(ref_clk), .pll_clk_i(pll_clk),
    .pll_lock_i(lock), .rx_act_i(rx_act), .tx_act_i(tx_act),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .sys_clk_o(sys_clk), .rx_clk_o(rx_clk), .tx_clk_o(tx_clk),
    .sys_src_o(sys_src), .rx_src_o(rx_src), .tx_src_o(tx_src)
  );

  always @(posedge sys_clk) begin
    n_sys++;
    if (t_fall >= 0.0 && $realtime - t_fall < min_w) min_w = $realtime - t_fall;
    t_rise = $realtime;
  end
  always @(negedge sys_clk) begin
    if (t_rise >= 0.0 && $realtime - t_rise < min_w) min_w = $realtime - t_rise;
    t_fall = $realtime;
  end
  always @(posedge rx_clk) n_rx++;
  always @(posedge tx_clk) n_tx++;

  // fields: cfg[21:14] lock[13] rx[12] tx[11] pll_on[10] sys[9:8] rx[7:6] tx[5:4] req[3:0]
  // source codes: 0 off, 1 reference, 2 PLL
  localparam int NV = 18;
  localparam logic [21:0] VECS [NV] = '{
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 4'd2},  // R2 lock high
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 4'd2},  // R2 lock drop
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 4'd6},  // R6 rx demand
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 2'd2, 4'd8},  // R8 tx demand
    {8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 4'd3},  // R3 force ref
    {8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 4'd3},  // R3 force pll
    {8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 4'd4},  // R4 no lock
    {8'h03, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 4'd4},  // R4 lock
    {8'h04, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1, 2'd0, 4'd7},  // R7 rx ref
    {8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd2, 2'd0, 4'd7},  // R7 rx pll
    {8'h0C, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 4'd7},  // R7 rx off
    {8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd1, 4'd8},  // R8 tx ref
    {8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 2'd2, 4'd8},  // R8 tx pll
    {8'h30, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 2'd0, 4'd8},  // R8 tx off
    {8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 2'd0, 4'd9},  // R9 reserved
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 4'd2},  // R2 prepare
    {8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 4'd5},  // R5 stall
    {8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 4'd5}   // R5 resume
  };

  function automatic logic [1:0] classify(input int n);
    if (n == 0) return 2'd0;
    if (n >= 8 && n <= 40) return 2'd1;
    if (n >= 100) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int ds, output int dr, output int dt);
    int s0, r0, t0;
    s0 = n_sys; r0 = n_rx; t0 = n_tx;
    #1040;
    ds = n_sys - s0; dr = n_rx - r0; dt = n_tx - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ds, dr, dt;
    // R1: reset state
    lock = 1'b1;
    repeat (4) @(negedge ref_clk);
    measure(ds, dr, dt);
    check("R1 rdata", cfg_rdata, 0);
    check("R1 sys_src", sys_src, 0);
    check("R1 rx_src", rx_src, 0);
    check("R1 tx_src", tx_src, 0);
    check("R1 edges", ds + dr + dt, 0);
    @(negedge ref_clk);
    lock = 1'b0;
    rst_n = 1'b1;
    repeat (8) @(negedge ref_clk);
    measure(ds, dr, dt);
    check("R1 auto sys_src", sys_src, 1);
    check("R1 auto sys edges", classify(ds), 1);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      @(negedge ref_clk);
      cfg_we = 1'b1; cfg_wdata = v[21:14];
      lock = v[13]; rx_act = v[12]; tx_act = v[11]; pll_on = v[10];
      @(negedge ref_clk);
      cfg_we = 1'b0;
      check({tag, " R9 rdata"}, cfg_rdata, {2'b00, v[19:14]});
      repeat (8) @(negedge ref_clk);
      measure(ds, dr, dt);
      check({tag, " sys_src"}, sys_src, v[9:8]);
      check({tag, " rx_src"}, rx_src, v[7:6]);
      check({tag, " tx_src"}, tx_src, v[5:4]);
      check({tag, " sys edges"}, classify(ds), v[9:8]);
      check({tag, " rx edges"}, classify(dr), v[7:6]);
      check({tag, " tx edges"}, classify(dt), v[5:4]);
    end

    // R10: no runt pulse across all switches (PLL half period 4 ns)
    check("R10 min pulse ok", (min_w >= 3.9) ? 1 : 0, 1);
    // R10: mid-switch, status never shows both
    check("R10 sys_src not 11", (sys_src == 2'b11) ? 1 : 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule